// File: doc/BRIEF.md
# SPI Master with Per-Frame Command Words

This block is an SPI bus master. Software, or any other producer, hands it 32-bit command words through a valid/ready push port. Each word holds up to 16 bits of transmit data and the controls for that one frame:

- which chip-select lines to drive;
- which clock/format attribute set to apply;
- whether chip select stays asserted once the frame ends.

Words wait in a four-entry transmit FIFO. The shift engine takes them one at a time and produces SCK, MOSI and the chip selects. It samples MISO and places one result word per frame into a four-entry receive FIFO, which a consumer drains through a valid/ready pop port.

Plain control pins select master operation, halt the engine, clear either FIFO and set the idle level of each chip-select line. A divider input sets the SCK half period. Two attribute sets are wired in as pins. Each set gives the frame size minus one, the clock polarity, the clock phase and the bit order. A status word reports the fill levels, a running bit and two sticky error flags.

On the push port, `push_ready_o` is low while the transmit FIFO is full or being cleared. A word offered while ready is low is dropped rather than held. On the pop port, `pop_valid_o` is high while received words wait. Raising `pop_ready_i` while valid is low counts as an empty read: it returns zero.

Top module: `spi_cmd_master`

## Requirements
- R1: A push with `push_ready_o` high enqueues the word. `push_ready_o` is high exactly when fewer than 4 words are queued and no TX clear is applied. Status bits 15:12 give the TX FIFO fill count.
- R2: A push while `push_ready_o` is low is dropped and sets status bit 1. Bit 1 stays set until a TX clear.
- R3: A frame has (attribute bits 3:0)+1 bits, from 1 to 16. Bits go out most significant first when attribute bit 6 is 0 and least significant first when it is 1. There is exactly one sampling edge per bit.
- R4: Attribute bit 4 sets the SCK idle level (CPOL). Attribute bit 5 sets the phase (CPHA). With phase 0, data is sampled on the edge leaving idle. With phase 1, data is sampled on the edge returning to idle.
- R5: Command bits 30:28 pick the attribute set, taken modulo the number of sets. With two sets, the low bit chooses between them.
- R6: Command bits 21:16 are a one-hot chip-select mask. Line n idles at `cs_idle_i[n]` and takes the opposite level while it is selected.
- R7: When command bit 31 is set, the selected lines stay asserted after the frame. A following frame with bit 31 clear releases them when it ends.
- R8: Each frame adds one receive word. Bits 15:0 hold the received data, with unused upper bits zero, and bits 31:16 repeat bits 31:16 of the command. Words pop in order, and status bits 7:4 give the RX fill count.
- R9: Raising `pop_ready_i` while `pop_valid_o` is low gives `pop_data_o` = 0 and sets status bit 0. Bit 0 stays set until an RX clear.
- R10: A frame starts only while `master_en_i` is 1 and `halt_i` is 0. Status bit 30 reports that condition.
- R11: `clr_tx_i` empties the TX FIFO and clears status bit 1 in one cycle. `clr_rx_i` does the same for the RX FIFO and status bit 0.
- R12: No frame starts while the RX FIFO holds 4 words. Words stay queued until space frees.
- R13: Each SCK half period lasts `div_i` clock cycles. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en_i | input | 1 | Master operation enable |
| halt_i | input | 1 | Stops new frames from starting |
| clr_tx_i | input | 1 | TX FIFO clear strobe |
| clr_rx_i | input | 1 | RX FIFO clear strobe |
| cs_idle_i | input | 6 | Idle level of each chip-select line |
| attr_i | input | 14 | Attribute sets, 7 bits each, set 0 in the low bits |
| div_i | input | 8 | SCK half period in clock cycles |
| push_valid_i | input | 1 | Command word offered |
| push_ready_o | output | 1 | TX FIFO can accept a word |
| push_data_i | input | 32 | Command word |
| pop_valid_o | output | 1 | Receive word available |
| pop_ready_i | input | 1 | Consumer takes the receive word |
| pop_data_o | output | 32 | Receive word, or zero when empty |
| status_o | output | 32 | Running bit, fill counts, sticky flags |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 6 | Chip-select lines |

## Verification
The assertions assume one-hot chip-select masks. They also assume `div_i` and the selected attribute set do not change while a frame is in flight. Finally, they assume the polarity of consecutive frames stays the same while chip select is held continuous.

The stimulus changes attributes and the divider only while the RX FIFO shows a frame has finished and the TX FIFO is empty. Every command it pushes names one line. MISO is looped back from MOSI, so the receive word can be predicted from the transmit data alone. A separate serial monitor decodes MOSI on the sampling edge of the mode under test.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int NUM_CS  = 6;
  localparam int ATTR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int CMD_CONT   = 31;
  localparam int CMD_SEL_LO = 28;
  localparam int CMD_CS_LO  = 16;

  typedef struct packed {
    logic       lsb_first;
    logic       cpha;
    logic       cpol;
    logic [3:0] size_m1;
  } attr_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_SHIFT,
    ENG_TAIL
  } eng_state_t;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_i,
  output logic [W-1:0]  rd_data_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= nxt(wp_q);
      if (rd_i) rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(wr_i) - CW'(rd_i);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i && !clr_i) mem[wp_q] <= wr_data_i;
  end

  assign rd_data_o = mem[rp_q];
  assign count_o   = cnt_q;

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i) |-> (cnt_q < CW'(DEPTH)));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !clr_i) |-> (cnt_q != '0));
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       tag_i,
  input  logic [DATA_W-1:0] data_i,
  input  attr_t             attr_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_act_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       rx_o
);
  eng_state_t        state_q;
  attr_t             attr_q;
  logic [15:0]       tag_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [NUM_CS-1:0] cs_q;
  logic [DIV_W-1:0]  half_q, reload;
  logic [4:0]        edge_q, oidx_q, iidx_q;
  logic              sck_q;
  logic              leading, samp_edge, shift_edge, last_edge;

  function automatic logic [3:0] bitpos(input logic [4:0] idx, input attr_t a);
    return a.lsb_first ? idx[3:0] : (a.size_m1 - idx[3:0]);
  endfunction

  assign reload     = (div_i == '0) ? '0 : div_i - 1'b1;
  assign leading    = ~edge_q[0];
  assign samp_edge  = leading ^ attr_q.cpha;
  assign shift_edge = !samp_edge && (edge_q != '0);
  assign last_edge  = (edge_q == {attr_q.size_m1, 1'b1});
  assign done_o     = (state_q == ENG_TAIL) && (half_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      attr_q  <= '0;
      tag_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      cs_q    <= '0;
      half_q  <= '0;
      edge_q  <= '0;
      oidx_q  <= '0;
      iidx_q  <= '0;
      sck_q   <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: if (start_i) begin
          attr_q  <= attr_i;
          tag_q   <= tag_i;
          tx_q    <= data_i;
          rx_q    <= '0;
          edge_q  <= '0;
          oidx_q  <= '0;
          iidx_q  <= '0;
          sck_q   <= attr_i.cpol;
          state_q <= ENG_SETUP;
        end
        ENG_SETUP: begin
          cs_q    <= tag_q[NUM_CS-1:0];
          half_q  <= reload;
          state_q <= ENG_SHIFT;
        end
        ENG_SHIFT: begin
          if (half_q != '0) begin
            half_q <= half_q - 1'b1;
          end else begin
            half_q <= reload;
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 1'b1;
            if (samp_edge) begin
              rx_q[bitpos(iidx_q, attr_q)] <= miso_i;
              iidx_q <= iidx_q + 1'b1;
            end
            if (shift_edge) oidx_q <= oidx_q + 1'b1;
            if (last_edge) state_q <= ENG_TAIL;
          end
        end
        ENG_TAIL: begin
          if (half_q != '0) begin
            half_q <= half_q - 1'b1;
          end else begin
            if (!tag_q[CMD_CONT-16]) cs_q <= '0;
            state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = tx_q[bitpos(oidx_q, attr_q)];
  assign cs_act_o = cs_q;
  assign busy_o   = (state_q != ENG_IDLE);
  assign rx_o     = {tag_q, rx_q};

  assert_frame_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (iidx_q == 5'(attr_q.size_m1) + 5'd1));
  assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !tag_q[CMD_CONT-16]) |=> (cs_act_o == '0));
  assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_SETUP) |=> $stable(sck_o));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int NUM_ATTR = 2,
  parameter int DIV_W    = 8,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int AIW     = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       master_en_i,
  input  logic                       halt_i,
  input  logic                       clr_tx_i,
  input  logic                       clr_rx_i,
  input  logic [NUM_CS-1:0]          cs_idle_i,
  input  logic [NUM_ATTR*ATTR_W-1:0] attr_i,
  input  logic [DIV_W-1:0]           div_i,
  input  logic                       push_valid_i,
  output logic                       push_ready_o,
  input  logic [31:0]                push_data_i,
  output logic                       pop_valid_o,
  input  logic                       pop_ready_i,
  output logic [31:0]                pop_data_o,
  output logic [31:0]                status_o,
  output logic                       sck_o,
  output logic                       mosi_o,
  input  logic                       miso_i,
  output logic [NUM_CS-1:0]          cs_o
);
  attr_t             attr_set [NUM_ATTR];
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic [31:0]       tx_head, rx_head, eng_rx;
  logic              tx_wr, rx_rd, start, running;
  logic              eng_busy, eng_done;
  logic [NUM_CS-1:0] cs_act;
  logic [AIW-1:0]    aidx;
  logic              ovf_q, udf_q;

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_attr
    assign attr_set[g] = attr_t'(attr_i[g*ATTR_W +: ATTR_W]);
  end

  assign running      = master_en_i && !halt_i;
  assign push_ready_o = (tx_cnt < CW'(DEPTH)) && !clr_tx_i;
  assign tx_wr        = push_valid_i && push_ready_o;
  assign start        = running && !eng_busy && !clr_tx_i &&
                        (tx_cnt != '0) && (rx_cnt < CW'(DEPTH));
  assign aidx         = AIW'({1'b0, tx_head[CMD_SEL_LO +: 3]} % 4'(NUM_ATTR));
  assign pop_valid_o  = (rx_cnt != '0);
  assign rx_rd        = pop_valid_o && pop_ready_i;
  assign pop_data_o   = pop_valid_o ? rx_head : '0;

  spi_cmd_fifo #(.W(32), .DEPTH(DEPTH)) tx_fifo_i (
    .clk, .rst_n, .clr_i(clr_tx_i), .wr_i(tx_wr), .wr_data_i(push_data_i),
    .rd_i(start), .rd_data_o(tx_head), .count_o(tx_cnt));

  spi_cmd_fifo #(.W(32), .DEPTH(DEPTH)) rx_fifo_i (
    .clk, .rst_n, .clr_i(clr_rx_i), .wr_i(eng_done), .wr_data_i(eng_rx),
    .rd_i(rx_rd), .rd_data_o(rx_head), .count_o(rx_cnt));

  spi_cmd_shifter #(.DIV_W(DIV_W)) shifter_i (
    .clk, .rst_n, .start_i(start), .tag_i(tx_head[31:16]),
    .data_i(tx_head[DATA_W-1:0]), .attr_i(attr_set[aidx]), .div_i,
    .miso_i, .sck_o, .mosi_o, .cs_act_o(cs_act), .busy_o(eng_busy),
    .done_o(eng_done), .rx_o(eng_rx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (clr_tx_i) ovf_q <= 1'b0;
      else if (push_valid_i && !push_ready_o) ovf_q <= 1'b1;
      if (clr_rx_i) udf_q <= 1'b0;
      else if (pop_ready_i && !pop_valid_o) udf_q <= 1'b1;
    end
  end

  assign cs_o     = cs_idle_i ^ cs_act;
  assign status_o = {1'b0, running, 14'b0, 4'(tx_cnt), 4'b0, 4'(rx_cnt),
                     2'b0, ovf_q, udf_q};

  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !eng_busy) |=> !eng_busy);
  assert_rx_room_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> (rx_cnt < CW'(DEPTH)));
  assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_tx_i) |=> ovf_q);
  assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_q && !clr_rx_i) |=> udf_q);
endmodule

// File: tb/spi_cmd_master_tb.sv
`timescale 1ns/1ps
module spi_cmd_master_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        master_en = 1'b1, halt = 1'b1, clr_tx = 1'b0, clr_rx = 1'b0;
  logic [5:0]  idle = 6'b101001;
  logic [13:0] attrs = '0;
  logic [7:0]  div = 8'd2;
  logic        push_valid = 1'b0, pop_ready = 1'b0;
  logic [31:0] push_data = '0;
  logic        push_ready, pop_valid, sck, mosi;
  logic [31:0] pop_data, status;
  logic [5:0]  cs;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_cmd_master dut_i (
    .clk, .rst_n, .master_en_i(master_en), .halt_i(halt), .clr_tx_i(clr_tx),
    .clr_rx_i(clr_rx), .cs_idle_i(idle), .attr_i(attrs), .div_i(div),
    .push_valid_i(push_valid), .push_ready_o(push_ready), .push_data_i(push_data),
    .pop_valid_o(pop_valid), .pop_ready_i(pop_ready), .pop_data_o(pop_data),
    .status_o(status), .sck_o(sck), .mosi_o(mosi), .miso_i(mosi), .cs_o(cs));

  // serial monitor
  logic        mon_cpol = 0, mon_cpha = 0;
  logic [31:0] mon_cap = '0;
  int          mon_edges = 0;
  time         mon_last = 0, mon_per = 0;
  logic [5:0]  mon_seen = '0;

  always @(posedge sck or negedge sck)
    if ((cs ^ idle) != '0 && sck == (mon_cpol ^ ~mon_cpha)) begin
      mon_cap = {mon_cap[30:0], mosi};
      mon_edges++;
      if (mon_last != 0) mon_per = $time - mon_last;
      mon_last = $time;
    end
  always @(negedge clk) mon_seen = mon_seen | (cs ^ idle);

  task automatic mon_reset(input logic cpol, input logic cpha);
    mon_cpol = cpol; mon_cpha = cpha; mon_cap = '0; mon_edges = 0;
    mon_last = 0; mon_per = 0; mon_seen = '0;
  endtask

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, got, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); push_valid = 1'b1; push_data = w;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic wait_rx(input int cnt);
    for (int n = 0; n < 20000 && int'(status[7:4]) < cnt; n++) @(negedge clk);
  endtask

  task automatic pop(output logic [31:0] w);
    wait_rx(1);
    @(negedge clk); w = pop_data; pop_ready = 1'b1;
    @(negedge clk); pop_ready = 1'b0;
  endtask

  task automatic strobe_tx(); @(negedge clk); clr_tx = 1; @(negedge clk); clr_tx = 0; endtask
  task automatic strobe_rx(); @(negedge clk); clr_rx = 1; @(negedge clk); clr_rx = 0; endtask

  function automatic logic [31:0] exp_cap(input logic [15:0] d, input logic [3:0] sz, input logic lsb);
    logic [31:0] r = '0;
    for (int i = 0; i <= int'(sz); i++) r[i] = lsb ? d[int'(sz) - i] : d[i];
    return r;
  endfunction

  function automatic logic [15:0] mask(input logic [3:0] sz);
    return 16'((32'd2 << sz) - 1);
  endfunction

  function automatic logic [31:0] cmd(input logic cont, input logic [2:0] sel,
                                      input logic [2:0] csn, input logic [15:0] d);
    return {cont, sel, 6'b0, 6'(1 << csn), d};
  endfunction

  // {attr[6:0], sel[2:0], cs index[2:0], data[15:0]}
  localparam logic [28:0] VEC [6] = '{
    {7'b0000111, 3'd0, 3'd0, 16'h00A5},
    {7'b1111111, 3'd1, 3'd3, 16'h1234},
    {7'b0100111, 3'd2, 3'd5, 16'h003C},
    {7'b1011111, 3'd3, 3'd1, 16'hBEEF},
    {7'b0001111, 3'd0, 3'd2, 16'h8001},
    {7'b1100111, 3'd1, 3'd4, 16'hFF81}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w, word;
    logic [6:0]  a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R10 status after reset (halted)", status, 32'h0);
    chk("R1 push_ready after reset", {31'b0, push_ready}, 32'd1);
    chk("R6 cs idle levels", {26'b0, cs}, {26'b0, idle});
    chk("R8 pop_valid after reset", {31'b0, pop_valid}, 32'd0);

    // halt: words stay queued
    push(cmd(0, 0, 0, 16'h0011));
    push(cmd(0, 0, 0, 16'h0022));
    repeat (50) @(negedge clk);
    chk("R10 halted keeps tx count", {28'b0, status[15:12]}, 32'd2);
    chk("R10 halted no rx", {28'b0, status[7:4]}, 32'd0);
    chk("R1 cs idle while halted", {26'b0, cs}, {26'b0, idle});

    // overflow
    push(cmd(0, 0, 0, 16'h0033));
    push(cmd(0, 0, 0, 16'h0044));
    chk("R1 push_ready low when full", {31'b0, push_ready}, 32'd0);
    push(cmd(0, 0, 0, 16'h0055));
    chk("R2 count stays 4 after drop", {28'b0, status[15:12]}, 32'd4);
    chk("R2 overflow flag", {31'b0, status[1]}, 32'd1);
    strobe_tx();
    chk("R11 tx clear empties", {28'b0, status[15:12]}, 32'd0);
    chk("R11 tx clear drops overflow flag", {31'b0, status[1]}, 32'd0);

    halt = 1'b0;
    @(negedge clk);
    chk("R10 running bit", {31'b0, status[30]}, 32'd1);

    // table of frames
    foreach (VEC[i]) begin
      a = VEC[i][28:22];
      attrs = (VEC[i][19] == 1'b0) ? {~a, a} : {a, ~a};
      mon_reset(a[4], a[5]);
      word = cmd(0, VEC[i][21:19], VEC[i][18:16], VEC[i][15:0]);
      push(word);
      pop(w);
      chk($sformatf("R8 rx word vec%0d", i), w,
          {word[31:16], VEC[i][15:0] & mask(a[3:0])});
      chk($sformatf("R3 R4 R5 serial bits vec%0d", i),
          mon_cap & {16'b0, mask(a[3:0])}, exp_cap(VEC[i][15:0], a[3:0], a[6]));
      chk($sformatf("R3 edge count vec%0d", i), mon_edges, int'(a[3:0]) + 1);
      chk($sformatf("R6 line driven vec%0d", i), {26'b0, mon_seen},
          {26'b0, 6'(1 << VEC[i][18:16])});
      chk($sformatf("R7 released vec%0d", i), {26'b0, cs}, {26'b0, idle});
      chk($sformatf("R13 period vec%0d", i), 32'(mon_per), 32'd20);
    end

    // continuous chip select
    attrs = {7'b0, 7'b0000111};
    mon_reset(0, 0);
    push(cmd(1, 0, 2, 16'h005A));
    pop(w);
    chk("R7 cs held after continuous frame", {31'b0, cs[2] ^ idle[2]}, 32'd1);
    push(cmd(0, 0, 2, 16'h00C3));
    pop(w);
    chk("R7 second frame data", {16'b0, w[15:0]}, 32'h00C3);
    chk("R7 cs released after closing frame", {26'b0, cs}, {26'b0, idle});

    // divider
    div = 8'd3; mon_reset(0, 0);
    push(cmd(0, 0, 0, 16'h0096)); pop(w);
    chk("R13 period div3", 32'(mon_per), 32'd30);
    div = 8'd0; mon_reset(0, 0);
    push(cmd(0, 0, 0, 16'h0069)); pop(w);
    chk("R13 period div0", 32'(mon_per), 32'd10);
    div = 8'd2;

    // rx full stall
    halt = 1'b1;
    for (int k = 0; k < 4; k++) push(cmd(0, 0, 1, 16'(8'h10 + k)));
    halt = 1'b0;
    wait_rx(4);
    push(cmd(0, 0, 1, 16'h0014));
    repeat (200) @(negedge clk);
    chk("R12 rx full holds", {28'b0, status[7:4]}, 32'd4);
    chk("R12 tx word waits", {28'b0, status[15:12]}, 32'd1);
    chk("R12 no cs while stalled", {26'b0, cs}, {26'b0, idle});
    pop(w);
    chk("R8 fifo order first", {16'b0, w[15:0]}, 32'h0010);
    wait_rx(4);
    repeat (4) @(negedge clk);
    chk("R12 resumes after pop", {28'b0, status[15:12]}, 32'd0);
    pop(w);
    chk("R8 fifo order second", {16'b0, w[15:0]}, 32'h0011);
    strobe_rx();
    chk("R11 rx clear empties", {28'b0, status[7:4]}, 32'd0);

    // underflow
    @(negedge clk); pop_ready = 1'b1;
    #1 chk("R9 empty pop data zero", pop_data, 32'h0);
    @(negedge clk); pop_ready = 1'b0;
    chk("R9 underflow flag", {31'b0, status[0]}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R9 underflow sticky", {31'b0, status[0]}, 32'd1);
    strobe_rx();
    chk("R11 rx clear drops underflow", {31'b0, status[0]}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule